// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small storage register with parallel data in and parallel data out. On each rising clock edge a two-bit mode input chooses one of four actions: keep the contents, move every bit one place toward the least significant end, move every bit one place toward the most significant end, or copy the parallel input word. Each shift direction has its own serial input. The bit that a shift empties is filled from the serial input for that direction.

An active-low clear input empties the register at once, with no clock edge needed. While clear is held low it overrides every mode. The parallel output is the register itself, so it shows the stored word at all times. The width is a parameter (default 4, minimum 2). Shifts always move exactly one place per cycle.

Top module: `uni_shift_reg`

## Requirements
- R1: With mode 2'b00 (hold), a rising edge leaves `q` unchanged.
- R2: With mode 2'b01 (shift right), a rising edge makes `q` equal to `{sin_r, q[WIDTH-1:1]}`: bits move toward bit 0, and `sin_r` enters at the MSB.
- R3: With mode 2'b10 (shift left), a rising edge makes `q` equal to `{q[WIDTH-2:0], sin_l}`: bits move toward the MSB, and `sin_l` enters at bit 0.
- R4: With mode 2'b11 (load), a rising edge makes `q` equal to `d`.
- R5: `q` changes only on a rising edge of `clk` or when `clr_n` goes low. Changes to `mode`, `d`, `sin_r` or `sin_l` between edges do not reach `q`.
- R6: Driving `clr_n` low forces `q` to all zeros at once, with no clock edge.
- R7: While `clr_n` is low, `q` stays all zeros across rising edges, whatever the mode and data inputs are.
- R8: A serial input that the current mode does not use has no effect. `sin_l` is ignored in shift right, and `sin_r` is ignored in shift left, hold and load.
- R9: The two shift directions may follow each other with no idle cycle. Each shift acts on the result of the shift just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all mode actions happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; highest priority |
| mode | input | 2 | Action: 00 hold, 01 shift right, 10 shift left, 11 load |
| sin_r | input | 1 | Serial input that enters at the MSB on a right shift |
| sin_l | input | 1 | Serial input that enters at bit 0 on a left shift |
| d | input | WIDTH | Parallel load word |
| q | output | WIDTH | Current register contents |

## Verification
The output is the register itself, so a wrong stored bit shows on `q` in the cycle after the edge that caused it. Every later shift then carries the error one place per cycle toward an end of the word. The bench therefore compares `q` with an arithmetic model after every edge. It sweeps every start word, mode, load word and pair of serial bits for the 4-bit default, and then runs a long chain of mixed shifts in both directions. Clear is checked between edges, so that a missing asynchronous path shows up before any clock edge could hide it.

// File: rtl/uni_shift_pkg.sv
// Package: shared mode encoding of the universal shift register.
// Assumes: the two-bit encoding below is fixed and decoded by every bit cell.
package uni_shift_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } shift_mode_e;
endpackage

// File: rtl/uni_shift_cell.sv
// Module: next-value selector for one register bit.
// Assumes: nbr_hi is the bit just above (or the right-shift serial input at
// the MSB), and nbr_lo is the bit just below (or the left-shift serial input
// at bit 0).
module uni_shift_cell
    import uni_shift_pkg::*;
(
    input  shift_mode_e mode,
    input  logic        cur,
    input  logic        nbr_hi,
    input  logic        nbr_lo,
    input  logic        par,
    output logic        nxt
);
    // Pick the bit that this position takes on the coming edge.
    always_comb begin
        unique case (mode)
            MODE_HOLD:  nxt = cur;
            MODE_RIGHT: nxt = nbr_hi;
            MODE_LEFT:  nxt = nbr_lo;
            default:    nxt = par;
        endcase
    end
endmodule

// File: rtl/uni_shift_store.sv
// Module: WIDTH storage flops with an asynchronous active-low clear.
// Assumes: clr_n is released away from a rising clk edge.
module uni_shift_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    // Capture the next word on the rising edge; clear at once when clr_n falls.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
    end

    // R7
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            clear_hold_chk: assert (q == '0);
        end
    end
endmodule

// File: rtl/uni_shift_reg.sv
// Module: universal shift register (hold, shift right, shift left, load).
// Assumes: WIDTH >= 2; mode, d and the serial inputs are stable around the
// rising edge of clk.
module uni_shift_reg
    import uni_shift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             sin_r,
    input  logic             sin_l,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    shift_mode_e      mode_e;
    logic [WIDTH-1:0] nxt;

    // Map the raw mode pins onto the shared encoding.
    always_comb mode_e = shift_mode_e'(mode);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic hi;
        logic lo;
        if (i == MSB) begin : g_top
            // The MSB takes the right-shift serial input from above.
            always_comb hi = sin_r;
        end else begin : g_mid_hi
            // Other bits take the bit just above them.
            always_comb hi = q[i+1];
        end
        if (i == 0) begin : g_bot
            // Bit 0 takes the left-shift serial input from below.
            always_comb lo = sin_l;
        end else begin : g_mid_lo
            // Other bits take the bit just below them.
            always_comb lo = q[i-1];
        end
        uni_shift_cell u_cell (
            .mode   (mode_e),
            .cur    (q[i]),
            .nbr_hi (hi),
            .nbr_lo (lo),
            .par    (d[i]),
            .nxt    (nxt[i])
        );
    end

    uni_shift_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .q     (q)
    );

    // R1
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> $stable(q));
    // R2
    right_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q == {$past(sin_r), $past(q[MSB:1])}));
    // R3
    left_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (q == {$past(q[MSB-1:0]), $past(sin_l)}));
    // R4
    load_word_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (q == $past(d)));
endmodule

// File: tb/uni_shift_reg_test.sv
// Bench: exhaustive sweep of the 4-bit register against an arithmetic model.
module uni_shift_reg_test;
    localparam int W = 4;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         sin_r = 1'b0;
    logic         sin_l = 1'b0;
    logic [W-1:0] d = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    uni_shift_reg #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .mode(mode), .sin_r(sin_r),
        .sin_l(sin_l), .d(d), .q(q)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] s,
        input logic [1:0] m, input logic [W-1:0] dd, input logic sr,
        input logic sl);
        case (m)
            2'b00:   return s;
            2'b01:   return (W'(sr) << (W-1)) | (s >> 1);
            2'b10:   return ((s << 1) & MASK) | W'(sl);
            default: return dd;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic sr,
                                     input logic sl);
        case (m)
            2'b00:   return "R1";
            2'b01:   return sl ? "R2/R8" : "R2";
            2'b10:   return sr ? "R3/R8" : "R3";
            default: return "R4";
        endcase
    endfunction

    // Inputs are driven at the falling edge; q is sampled one falling edge later.
    task automatic step(input logic [1:0] m, input logic [W-1:0] dd,
                        input logic sr, input logic sl);
        mode = m; d = dd; sin_r = sr; sin_l = sl;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] ref_q;
        logic [15:0]  lfsr;
        @(negedge clk);
        @(negedge clk);
        check("R6 reset", q, '0);
        clr_n = 1'b1;
        @(negedge clk);

        // Exhaustive sweep: every start word, mode, load word and serial pair.
        for (int s = 0; s < (1 << W); s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int dv = 0; dv < (1 << W); dv++) begin
                    for (int sp = 0; sp < 4; sp++) begin
                        step(2'b11, W'(s), 1'b0, 1'b0);
                        step(2'(m), W'(dv), sp[1], sp[0]);
                        check(tag_of(2'(m), sp[1], sp[0]), q,
                              model(W'(s), 2'(m), W'(dv), sp[1], sp[0]));
                    end
                end
            end
        end

        // R9: long chain of mixed modes, with opposite shifts back to back.
        step(2'b11, 4'b1001, 1'b0, 1'b0);
        ref_q = 4'b1001;
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [1:0] m;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m = (k % 2 == 0) ? 2'b01 : 2'b10;
            if (lfsr[7:6] == 2'b00) m = lfsr[1:0];
            step(m, lfsr[11:8], lfsr[2], lfsr[3]);
            ref_q = model(ref_q, m, lfsr[11:8], lfsr[2], lfsr[3]);
            check("R9 chain", q, ref_q);
        end

        // R5: input changes between edges do not reach q.
        step(2'b11, 4'b0110, 1'b0, 1'b0);
        mode = 2'b11; d = 4'b1111; sin_r = 1'b1; sin_l = 1'b1;
        #2;
        check("R5 mid-cycle", q, 4'b0110);
        mode = 2'b00;
        @(negedge clk);
        check("R5 hold after", q, 4'b0110);

        // R6: clear acts between edges, with no clock needed.
        mode = 2'b11; d = 4'b1010;
        @(posedge clk);
        #1;
        clr_n = 1'b0;
        #1;
        check("R6 async clear", q, '0);

        // R7: clear overrides every mode across edges.
        for (int m = 0; m < 4; m++) begin
            step(2'(m), 4'b1111, 1'b1, 1'b1);
            check("R7 clear priority", q, '0);
        end
        clr_n = 1'b1;
        step(2'b10, 4'b0000, 1'b0, 1'b1);
        check("R3 after clear", q, 4'b0001);
        step(2'b01, 4'b0000, 1'b1, 1'b0);
        check("R9 opposite shift", q, 4'b1000);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule